// File: doc/BRIEF.md
# Terminal Address Latch and Validator

This block takes the five-bit terminal address and its parity bit from strap pins and holds them for the rest of the terminal. While the latch-control pin is low, the address is hardwired and the held copy follows the pins. When the latch-control pin rises, the pins are sampled once and the held copy then ignores them until the pin drops again. An odd-parity check over the held address and parity bit drives a status flag.

The block also screens each incoming 16-bit command word. The decoder upstream presents each word with a single-cycle strobe. The address field sits in bits 15 down to 11. A field equal to the held address gives a one-cycle "for me" pulse, but only while the parity flag is good. When broadcast is enabled, the all-ones field gives a one-cycle broadcast pulse whatever the parity state. All pin inputs pass through a synchronizer, and every output is driven from registers clocked by the system clock.

Top module: `rt_addr_guard`

## Requirements
- R1: `parity_ok` is 1 when the held address and held parity bit together contain an odd number of ones, and 0 when they contain an even number.
- R2: While `addr_latch_pin` is low, `addr_q` and `parity_ok` follow the address and parity pins, 3 clock cycles after a pin change (two synchronizer stages plus the holding register).
- R3: A low-to-high transition on `addr_latch_pin` captures the pin values present at that edge. While the pin stays high, later changes on the address or parity pins do not change `addr_q` or `parity_ok`.
- R4: The cycle after a strobe whose bits 15:11 equal `addr_q` while `parity_ok` is 1, `cmd_for_me` is 1 for exactly one cycle and `cmd_bcast` stays 0. The broadcast case of R6 is the exception.
- R5: While `parity_ok` is 0, a command whose bits 15:11 equal `addr_q` gives no `cmd_for_me` pulse.
- R6: With `bcast_en` at 1, a command whose bits 15:11 are 31 (all ones) gives a one-cycle `cmd_bcast` pulse on the next cycle, whatever the state of `parity_ok`. It never gives `cmd_for_me`.
- R7: With `bcast_en` at 0, the field value 31 gives no `cmd_bcast`. It is matched like any other address, so it gives `cmd_for_me` when `addr_q` is 31 and `parity_ok` is 1.
- R8: Neither pulse is raised without a strobe on the previous cycle. A strobed word whose field matches neither the held address nor an enabled broadcast raises neither pulse.
- R9: In reset and on the first cycle after it, `addr_q` is 0, `parity_ok` is 0, and both pulse outputs are 0.
- R10: After `addr_latch_pin` returns low, the held address again follows the pins as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rt_addr_pins | input | 5 | Terminal address straps, asynchronous |
| rt_par_pin | input | 1 | Address parity strap, asynchronous |
| addr_latch_pin | input | 1 | Low: hardwired address; rising edge: capture |
| cmd_stb | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Command word; address field in bits 15:11 |
| bcast_en | input | 1 | Treat address 31 as broadcast |
| parity_ok | output | 1 | Held address has odd (correct) parity |
| addr_q | output | 5 | Held terminal address |
| cmd_for_me | output | 1 | One-cycle pulse: command for this terminal |
| cmd_bcast | output | 1 | One-cycle pulse: broadcast command |

## Verification
The assertions check on every cycle that pulses come only after a strobe and never both at once. They also check that a "for me" pulse always matches the held address under good parity, that broadcast pulses need the enable, and that the held address follows the synchronized pins when open and stays frozen when latched. Only the bench's scenarios can show the end-to-end behaviour: the parity flag value for concrete pin patterns, the three-cycle latency from pins, which pin value a latch edge actually captures, that bad parity still lets broadcasts through, and that address 31 acts as an ordinary address when broadcast is off.

// File: rtl/tal_pkg.sv
// Package: shared types for the terminal address guard.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tal_pkg;

    // How the holding register treats the synchronized pins this cycle.
    typedef enum logic [1:0] {
        SRC_OPEN    = 2'd0,   // latch control low: follow the pins
        SRC_CAPTURE = 2'd1,   // rising edge seen: take the pins once
        SRC_HOLD    = 2'd2    // latch control high after the edge: keep value
    } src_mode_t;

endpackage

// File: rtl/tal_sync.sv
// Module: tal_sync
// Multi-stage flop synchronizer for a bus of quasi-static strap inputs.
// Assumes the bits change rarely. A bus that changes between samples may
// show a mixed value for one cycle, which is acceptable for straps.
module tal_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/tal_addr_hold.sv
// Module: tal_addr_hold
// Holding register for the terminal address and its parity bit.
// Assumes the caller supplies synchronized pins and a mode decided from the
// synchronized latch-control level and its previous value.
module tal_addr_hold
    import tal_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_mode_t         mode,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              par_s,
    output logic [ADDR_W-1:0] addr_q,
    output logic              par_q
);

    // Load from the pins when open or capturing; keep the value when holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            par_q  <= 1'b0;
        end else if (mode != SRC_HOLD) begin
            addr_q <= addr_s;
            par_q  <= par_s;
        end
    end

endmodule

// File: rtl/tal_cmd_qual.sv
// Module: tal_cmd_qual
// Screens strobed command words against the held terminal address.
// Assumes cmd_stb is synchronous to clk and high for one cycle per word.
// The address field sits at FIELD_LSB upward, ADDR_W bits wide.
module tal_cmd_qual #(
    parameter int ADDR_W    = 5,
    parameter int WORD_W    = 16,
    parameter int FIELD_LSB = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              bcast_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_ok,
    output logic              for_me,
    output logic              bcast
);

    localparam logic [ADDR_W-1:0] BCAST_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] field;
    logic              is_bcast;
    logic              is_own;

    // Decode the address field of the presented word.
    always_comb begin
        field    = cmd_word[FIELD_LSB +: ADDR_W];
        is_bcast = bcast_en && (field == BCAST_ADDR);
        is_own   = !is_bcast && own_ok && (field == own_addr);
    end

    // Register one pulse per strobe; broadcast ignores parity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for_me <= 1'b0;
            bcast  <= 1'b0;
        end else begin
            for_me <= cmd_stb && is_own;
            bcast  <= cmd_stb && is_bcast;
        end
    end

endmodule

// File: rtl/rt_addr_guard.sv
// Module: rt_addr_guard (top)
// Terminal address latch and validator: synchronizes the address straps,
// holds them hardwired or edge-latched, checks odd parity and qualifies
// command words. Assumes strap pins are asynchronous and that the command
// strobe and word are already synchronous to clk.
module rt_addr_guard
    import tal_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int WORD_W      = 16,
    parameter int FIELD_LSB   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rt_addr_pins,
    input  logic              rt_par_pin,
    input  logic              addr_latch_pin,
    input  logic              cmd_stb,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              bcast_en,
    output logic              parity_ok,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cmd_for_me,
    output logic              cmd_bcast
);

    localparam int PIN_W = ADDR_W + 2;

    logic [PIN_W-1:0]  pins_s;
    logic [ADDR_W-1:0] addr_s;
    logic              par_s;
    logic              lat_s;
    logic              lat_prev;
    logic              par_q;
    src_mode_t         mode;

    tal_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr_latch_pin, rt_par_pin, rt_addr_pins}),
        .q     (pins_s)
    );

    assign addr_s = pins_s[ADDR_W-1:0];
    assign par_s  = pins_s[ADDR_W];
    assign lat_s  = pins_s[ADDR_W+1];

    // Remember the previous synchronized latch level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_prev <= 1'b0;
        else        lat_prev <= lat_s;
    end

    // Pick the address source from the latch level and its edge.
    always_comb begin
        if (!lat_s)        mode = SRC_OPEN;
        else if (!lat_prev) mode = SRC_CAPTURE;
        else               mode = SRC_HOLD;
    end

    tal_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .addr_s (addr_s),
        .par_s  (par_s),
        .addr_q (addr_q),
        .par_q  (par_q)
    );

    // Odd parity over the held address and parity bit means valid.
    assign parity_ok = ^{addr_q, par_q};

    tal_cmd_qual #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .FIELD_LSB (FIELD_LSB)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_stb  (cmd_stb),
        .cmd_word (cmd_word),
        .bcast_en (bcast_en),
        .own_addr (addr_q),
        .own_ok   (parity_ok),
        .for_me   (cmd_for_me),
        .bcast    (cmd_bcast)
    );

endmodule

// File: rtl/tal_guard_chk.sv
// Module: tal_guard_chk
// Checker for rt_addr_guard, attached with bind. Watches the ports plus
// the synchronized pins, the held parity bit and the source mode.
module tal_guard_chk
    import tal_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int WORD_W    = 16,
    parameter int FIELD_LSB = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb,
    input logic [WORD_W-1:0] cmd_word,
    input logic              bcast_en,
    input logic              parity_ok,
    input logic [ADDR_W-1:0] addr_q,
    input logic              par_q,
    input logic              cmd_for_me,
    input logic              cmd_bcast,
    input src_mode_t         mode,
    input logic [ADDR_W-1:0] addr_s,
    input logic              par_s
);

    // R8: a pulse needs a strobe on the cycle before.
    a_r8_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_for_me || cmd_bcast) |-> $past(cmd_stb));

    // R6: the two pulses never coincide.
    a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_for_me && cmd_bcast));

    // R6: broadcast needs the enable at the strobe.
    a_r6_bcast_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bcast |-> $past(bcast_en));

    // R4: a for-me pulse always matched the held address.
    a_r4_for_me_matches: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_for_me |-> ($past(cmd_word[FIELD_LSB +: ADDR_W]) == $past(addr_q)));

    // R5: a for-me pulse needs good parity at the strobe.
    a_r5_for_me_needs_parity: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_for_me |-> $past(parity_ok));

    // R3: while latched, the held address and parity stay put.
    a_r3_hold_when_latched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == SRC_HOLD) |-> ($stable(addr_q) && $stable(par_q)));

    // R2: when open or capturing, the holder takes the synchronized pins.
    a_r2_follow_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode != SRC_HOLD) |-> ({addr_q, par_q} == $past({addr_s, par_s})));

endmodule

bind rt_addr_guard tal_guard_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .FIELD_LSB (FIELD_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .cmd_word   (cmd_word),
    .bcast_en   (bcast_en),
    .parity_ok  (parity_ok),
    .addr_q     (addr_q),
    .par_q      (par_q),
    .cmd_for_me (cmd_for_me),
    .cmd_bcast  (cmd_bcast),
    .mode       (mode),
    .addr_s     (addr_s),
    .par_s      (par_s)
);

// File: tb/tb_rt_addr_guard.sv
// Directed bench for rt_addr_guard: one task per scenario, each checking
// its own results at the falling clock edge.
module tb_rt_addr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rt_addr_pins = '0;
    logic        rt_par_pin = 1'b0;
    logic        addr_latch_pin = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        bcast_en = 1'b0;
    logic        parity_ok;
    logic [4:0]  addr_q;
    logic        cmd_for_me;
    logic        cmd_bcast;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    rt_addr_guard dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rt_addr_pins   (rt_addr_pins),
        .rt_par_pin     (rt_par_pin),
        .addr_latch_pin (addr_latch_pin),
        .cmd_stb        (cmd_stb),
        .cmd_word       (cmd_word),
        .bcast_en       (bcast_en),
        .parity_ok      (parity_ok),
        .addr_q         (addr_q),
        .cmd_for_me     (cmd_for_me),
        .cmd_bcast      (cmd_bcast)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [4:0] a);
        return ~(^a);
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pins(input logic [4:0] a, input logic p);
        @(negedge clk);
        rt_addr_pins = a;
        rt_par_pin   = p;
        wait_cycles(4);
    endtask

    // Strobe one word, check both pulses next cycle and their end after that.
    task automatic send_cmd(input logic [4:0] field, input logic en,
                            input logic exp_me, input logic exp_bc, input string req);
        @(negedge clk);
        cmd_word = {field, 11'h2A5};
        bcast_en = en;
        cmd_stb  = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
        check(cmd_for_me == exp_me, {req, " for_me"}, cmd_for_me, exp_me);
        check(cmd_bcast == exp_bc, {req, " bcast"}, cmd_bcast, exp_bc);
        @(negedge clk);
        check(!cmd_for_me && !cmd_bcast, {req, " pulse one cycle"},
              {cmd_for_me, cmd_bcast}, 0);
    endtask

    task automatic t_reset();   // R9
        rst_n = 1'b0;
        wait_cycles(3);
        check(addr_q == 5'd0, "R9 addr in reset", addr_q, 0);
        check(parity_ok == 1'b0, "R9 parity in reset", parity_ok, 0);
        check(!cmd_for_me && !cmd_bcast, "R9 pulses in reset", {cmd_for_me, cmd_bcast}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_q == 5'd0 && parity_ok == 1'b0, "R9 after reset", addr_q, 0);
    endtask

    task automatic t_transparent();   // R1, R2
        logic [4:0] pats [4] = '{5'h00, 5'h15, 5'h0E, 5'h1F};
        foreach (pats[i]) begin
            set_pins(pats[i], good_par(pats[i]));
            check(addr_q == pats[i], "R2 addr follows pins", addr_q, pats[i]);
            check(parity_ok == 1'b1, "R1 odd parity good", parity_ok, 1);
            set_pins(pats[i], ~good_par(pats[i]));
            check(parity_ok == 1'b0, "R1 even parity bad", parity_ok, 0);
        end
        // R2 latency: three clocks from a pin change
        @(negedge clk);
        rt_addr_pins = 5'h09;
        rt_par_pin   = good_par(5'h09);
        wait_cycles(2);
        check(addr_q != 5'h09, "R2 not yet after two clocks", addr_q, 5'h1F);
        wait_cycles(1);
        check(addr_q == 5'h09, "R2 present after three clocks", addr_q, 9);
    endtask

    task automatic t_for_me();   // R4, R8
        set_pins(5'h06, good_par(5'h06));
        send_cmd(5'h06, 1'b1, 1'b1, 1'b0, "R4 own address");
        send_cmd(5'h07, 1'b1, 1'b0, 1'b0, "R8 other address");
        // R8: matching word present without strobe
        @(negedge clk);
        cmd_word = {5'h06, 11'h000};
        wait_cycles(3);
        check(!cmd_for_me && !cmd_bcast, "R8 no strobe no pulse", {cmd_for_me, cmd_bcast}, 0);
    endtask

    task automatic t_bad_parity();   // R5, R6
        set_pins(5'h06, ~good_par(5'h06));
        check(parity_ok == 1'b0, "R5 parity bad", parity_ok, 0);
        send_cmd(5'h06, 1'b1, 1'b0, 1'b0, "R5 own address blocked");
        send_cmd(5'h1F, 1'b1, 1'b0, 1'b1, "R6 broadcast with bad parity");
    endtask

    task automatic t_broadcast();   // R6, R7
        set_pins(5'h1F, good_par(5'h1F));
        send_cmd(5'h1F, 1'b1, 1'b0, 1'b1, "R6 broadcast not for_me");
        send_cmd(5'h1F, 1'b0, 1'b1, 1'b0, "R7 31 as own address");
        set_pins(5'h03, good_par(5'h03));
        send_cmd(5'h1F, 1'b0, 1'b0, 1'b0, "R7 no broadcast when disabled");
    endtask

    task automatic t_latch();   // R3, R10
        set_pins(5'h0C, good_par(5'h0C));
        @(negedge clk);
        addr_latch_pin = 1'b1;
        wait_cycles(4);
        check(addr_q == 5'h0C, "R3 captured at edge", addr_q, 12);
        set_pins(5'h03, ~good_par(5'h03));
        check(addr_q == 5'h0C, "R3 pins ignored while latched", addr_q, 12);
        check(parity_ok == 1'b1, "R3 parity held while latched", parity_ok, 1);
        send_cmd(5'h0C, 1'b0, 1'b1, 1'b0, "R3 latched address matches");
        send_cmd(5'h03, 1'b0, 1'b0, 1'b0, "R3 pin address not matched");
        @(negedge clk);
        addr_latch_pin = 1'b0;
        wait_cycles(4);
        check(addr_q == 5'h03, "R10 follows pins again", addr_q, 3);
        check(parity_ok == 1'b0, "R10 parity follows pins", parity_ok, 0);
        set_pins(5'h11, good_par(5'h11));
        check(addr_q == 5'h11 && parity_ok, "R10 new pins seen", addr_q, 17);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_for_me();
        t_bad_parity();
        t_broadcast();
        t_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule